// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream through two register stages. A capture register samples the parallel inputs whenever a one-cycle capture strobe is asserted. A shift register then takes that captured word when the mode control selects load. When the mode control selects shift, the shift register moves serial data in at the low end on a one-cycle shift strobe. The last stage of the shift register drives the serial output, so a loaded word leaves most significant bit first.

The two registers clear separately. A power-on reset clears both. A shift-clear input clears only the shift stages and leaves the captured word in place, so a word that was interrupted part-way through can be sent again with a new load. Everything runs in one clock domain and all resets are synchronous.

Top module: `latched_piso`

## Requirements
- R1: While `por_n` is low, `ser_out` reads 0 after the next clock edge.
- R2: A clock edge with `cap_stb` high copies `par_in` into the capture register. With `cap_stb` low the capture register holds its value.
- R3: With `mode_shift` high and `shift_stb` high, each clock edge moves `ser_in` into stage 0 and moves stage i-1 into stage i for every higher stage.
- R4: `ser_out` is the top stage (index WIDTH-1). After a load, the word leaves most significant bit first, one bit per shift.
- R5: With `mode_shift` low, the shift register takes the capture register contents on every clock edge, bit i into stage i. `shift_stb` and `ser_in` have no effect in this mode.
- R6: When `mode_shift` is low and `cap_stb` is high on the same edge, the shift register takes the capture register value from before that edge. The new word reaches the shift register on the following edge.
- R7: An edge with `shreg_clr_n` low clears every shift stage to 0, ahead of load and shift, and leaves the capture register unchanged.
- R8: With `mode_shift` high, `cap_stb` and `shift_stb` may both be high on one edge. The capture register then takes `par_in` and the shift register shifts on that same edge.
- R9: With `mode_shift` high and both strobes low, the shift stages keep their values whatever `ser_in` and `par_in` do.
- R10: A clock edge with `por_n` low clears the capture register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous active-low power-on reset; clears both registers |
| shreg_clr_n | input | 1 | Synchronous active-low clear of the shift stages only |
| cap_stb | input | 1 | One-cycle strobe that captures `par_in` |
| par_in | input | WIDTH | Parallel data word |
| mode_shift | input | 1 | 1 = shift mode, 0 = load mode |
| shift_stb | input | 1 | One-cycle strobe that shifts in shift mode |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial data from stage WIDTH-1 |

## Verification
The bench checks ordering at both ends: the bit order of a loaded word as it leaves, and the bit order of a serial pattern as it enters. A design with the shift direction or the stage numbering reversed would give back bit-reversed bytes. A shift-clear in the middle of a shift is followed by a reload and a full read-back. A design whose clear also reached the capture register would return zero at that point instead of the original byte. The bench also tests a capture in the same cycle as a load, where a design that forwards `par_in` straight through would show the new word's top bit one cycle early. A shift strobe and serial data applied in load mode must leave the loaded word intact. A capture together with a shift in shift mode must perform both operations.

// File: rtl/pis_pkg.sv
// Package: shared types for the latched parallel-to-serial register.
// Assumes: nothing beyond a single clock domain.
package pis_pkg;
    // Operating mode of the shift stages
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } stage_mode_e;
endpackage

// File: rtl/pis_capture_reg.sv
// Module: capture register. It holds the parallel word taken on a one-cycle
// strobe. Only the power-on reset clears it.
// Assumes: cap_stb is synchronous to clk.
module pis_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] store_q
);
    // Capture par_in on the strobe; clear on power-on reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            store_q <= '0;
        end else if (cap_stb) begin
            store_q <= par_in;
        end
    end

    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !cap_stb |=> $stable(store_q));
    // R2
    cap_take_chk: assert property (@(posedge clk) disable iff (!por_n)
        cap_stb |=> store_q == $past(par_in));
    // R10
    por_clear_chk: assert property (@(posedge clk)
        !por_n |=> store_q == '0);
endmodule

// File: rtl/pis_stage_cell.sv
// Module: one shift stage. It loads, shifts, holds or clears a single bit.
// Assumes: both clears are synchronous and active low, and clear wins.
module pis_stage_cell
    import pis_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        clr_n,
    input  stage_mode_e mode,
    input  logic        shift_en,
    input  logic        prev_bit,
    input  logic        load_bit,
    output logic        q
);
    // Next-state choice: clear, then load, then shift, else hold
    always_ff @(posedge clk) begin
        if (!por_n || !clr_n) begin
            q <= 1'b0;
        end else if (mode == MODE_LOAD) begin
            q <= load_bit;
        end else if (shift_en) begin
            q <= prev_bit;
        end
    end
endmodule

// File: rtl/pis_stage_chain.sv
// Module: a chain of WIDTH shift stages. Stage 0 takes the serial input and
// stage WIDTH-1 is the serial output.
// Assumes: WIDTH >= 2.
module pis_stage_chain
    import pis_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr_n,
    input  stage_mode_e      mode,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] stages
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] prev_vec;

    // Feed each stage from the one below it, and stage 0 from ser_in
    always_comb begin
        prev_vec = {stages[TOP-1:0], ser_in};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        pis_stage_cell u_cell (
            .clk      (clk),
            .por_n    (por_n),
            .clr_n    (clr_n),
            .mode     (mode),
            .shift_en (shift_en),
            .prev_bit (prev_vec[i]),
            .load_bit (load_word[i]),
            .q        (stages[i])
        );
    end

    // R7
    clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        !clr_n |=> stages == '0);
    // R5
    load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_n && mode == MODE_LOAD) |=> stages == $past(load_word));
    // R3
    shift_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_n && mode == MODE_SHIFT && shift_en)
        |=> stages[TOP:1] == $past(stages[TOP-1:0]) && stages[0] == $past(ser_in));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_n && mode == MODE_SHIFT && !shift_en) |=> $stable(stages));
endmodule

// File: rtl/latched_piso.sv
// Module: top of the latched-input parallel-to-serial shift register.
// Assumes: one clock domain and single-cycle strobes.
module latched_piso
    import pis_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             shreg_clr_n,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] par_in,
    input  logic             mode_shift,
    input  logic             shift_stb,
    input  logic             ser_in,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] stages;
    stage_mode_e      mode;

    // Decode the mode pin into the stage mode type
    always_comb begin
        mode = mode_shift ? MODE_SHIFT : MODE_LOAD;
    end

    pis_capture_reg #(.WIDTH(WIDTH)) u_capture (
        .clk     (clk),
        .por_n   (por_n),
        .cap_stb (cap_stb),
        .par_in  (par_in),
        .store_q (store_q)
    );

    pis_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .por_n     (por_n),
        .clr_n     (shreg_clr_n),
        .mode      (mode),
        .shift_en  (shift_stb),
        .ser_in    (ser_in),
        .load_word (store_q),
        .stages    (stages)
    );

    // Serial output comes from the top stage
    always_comb begin
        ser_out = stages[TOP];
    end

    // R6
    old_word_chk: assert property (@(posedge clk) disable iff (!por_n)
        (shreg_clr_n && !mode_shift && cap_stb) |=> stages == $past(store_q));
    // R7
    clr_keeps_store_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!shreg_clr_n && !cap_stb) |=> $stable(store_q));
    // R1
    por_out_chk: assert property (@(posedge clk)
        !por_n |=> !ser_out);
endmodule

// File: tb/test_latched_piso.sv
module test_latched_piso;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         shreg_clr_n = 1'b1;
    logic         cap_stb = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         mode_shift = 1'b1;
    logic         shift_stb = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Each entry is {word loaded in parallel, word pushed in serially}
    localparam logic [15:0] VEC [6] = '{
        16'hA5_3C, 16'h01_80, 16'h80_01, 16'hFF_00, 16'h00_FF, 16'h96_E7
    };

    always #2 clk = ~clk;

    latched_piso #(.WIDTH(W)) i_latched_piso (
        .clk(clk), .por_n(por_n), .shreg_clr_n(shreg_clr_n), .cap_stb(cap_stb),
        .par_in(par_in), .mode_shift(mode_shift), .shift_stb(shift_stb),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic capture(input logic [W-1:0] d);
        cap_stb = 1'b1; par_in = d;
        cyc();
        cap_stb = 1'b0;
    endtask

    // Sample before each shift; push fill MSB first
    task automatic shift_out(input logic [W-1:0] fill, output logic [W-1:0] got);
        mode_shift = 1'b1;
        for (int k = 0; k < W; k++) begin
            got[W-1-k] = ser_out;
            shift_stb = 1'b1; ser_in = fill[W-1-k];
            cyc();
        end
        shift_stb = 1'b0; ser_in = 1'b0;
    endtask

    task automatic read_store(output logic [W-1:0] got);
        mode_shift = 1'b0;
        cyc();
        shift_out('0, got);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        @(negedge clk);
        cyc(); cyc();
        // R1: serial output reads 0 during power-on reset
        check(ser_out == 1'b0, "R1", {7'b0, ser_out}, 8'h00);
        por_n = 1'b1;
        // R10: capture register cleared by power-on reset
        read_store(got);
        check(got == 8'h00, "R10", got, 8'h00);

        // Table: R2 capture, R4 MSB-first output, R3 serial entry order
        for (int v = 0; v < 6; v++) begin
            capture(VEC[v][15:8]);
            mode_shift = 1'b0; cyc();
            shift_out(VEC[v][7:0], got);
            check(got == VEC[v][15:8], "R4", got, VEC[v][15:8]);
            shift_out('0, got);
            check(got == VEC[v][7:0], "R3", got, VEC[v][7:0]);
        end

        // R6: capture during load gives old word first
        capture(8'hA5);
        mode_shift = 1'b0; cyc();
        cap_stb = 1'b1; par_in = 8'h3C;
        cyc();
        cap_stb = 1'b0;
        check(ser_out == 1'b1, "R6", {7'b0, ser_out}, 8'h01);
        cyc();
        check(ser_out == 1'b0, "R6", {7'b0, ser_out}, 8'h00);

        // R5: shift strobe and serial input ignored in load mode
        capture(8'h5A);
        mode_shift = 1'b0; shift_stb = 1'b1; ser_in = 1'b1;
        cyc(); cyc(); cyc();
        shift_stb = 1'b0; ser_in = 1'b0;
        shift_out('0, got);
        check(got == 8'h5A, "R5", got, 8'h5A);

        // R9: hold with no strobes in shift mode; R2 storage holds too
        capture(8'h71);
        mode_shift = 1'b0; cyc();
        mode_shift = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ser_in = k[0]; par_in = 8'hFF - 8'(k);
            cyc();
        end
        shift_out('0, got);
        check(got == 8'h71, "R9", got, 8'h71);
        read_store(got);
        check(got == 8'h71, "R2", got, 8'h71);

        // R7: clear mid-shift zeroes stages, storage intact
        capture(8'hC3);
        mode_shift = 1'b0; cyc();
        mode_shift = 1'b1; shift_stb = 1'b1; ser_in = 1'b1;
        cyc(); cyc(); cyc();
        shreg_clr_n = 1'b0;
        cyc();
        shreg_clr_n = 1'b1; shift_stb = 1'b0; ser_in = 1'b0;
        shift_out('0, got);
        check(got == 8'h00, "R7", got, 8'h00);
        mode_shift = 1'b0; shreg_clr_n = 1'b0;
        cyc();
        shreg_clr_n = 1'b1;
        check(ser_out == 1'b0, "R7", {7'b0, ser_out}, 8'h00);
        read_store(got);
        check(got == 8'hC3, "R7", got, 8'hC3);

        // R8: capture and shift on one edge in shift mode
        capture(8'hB4);
        mode_shift = 1'b0; cyc();
        mode_shift = 1'b1; cap_stb = 1'b1; par_in = 8'h2D; shift_stb = 1'b1;
        cyc();
        cap_stb = 1'b0; shift_stb = 1'b0;
        check(ser_out == 1'b0, "R8", {7'b0, ser_out}, 8'h00);
        read_store(got);
        check(got == 8'h2D, "R8", got, 8'h2D);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule